// File: doc/BRIEF.md
# Clock Fan-out Configuration Slave

This block is a two-wire serial slave that holds the configuration bytes of a clock fan-out buffer. Its first register carries one enable bit for each differential clock output. The other registers are general settings. All registers come out of reset at fixed defaults, so the buffer runs fully even when nothing on the bus ever touches it. SCL and SDA are brought into the system clock domain through two-flop synchronizers. SDA is only ever pulled low. The slave changes it only in the low phase of SCL.

A host reaches the registers in one of two ways, chosen by the most significant bit of the command byte that follows the address. With that bit set, the host gets indexed access to one register at the offset held in the low seven bits. With it clear, the host gets a block access that always begins at register zero and walks upward. A block write carries a byte count before its data. A block read answers with a count first. A read is started by a repeated START with the read address, and it uses the command latched during the write phase.

Top module: `cfgbus_slave`

## Requirements
- R1: The slave acknowledges the address byte 0xDC (write) or 0xDD (read), which is the 7-bit address 0x6E plus the direction bit in bit 0. For any other address it gives no acknowledge and leaves SDA released until the next START.
- R2: A command byte with bit 7 = 1 selects byte access at offset bits 6:0. It is acknowledged only when the offset is below 3, the register count; otherwise it is not acknowledged and the transaction is ignored.
- R3: A command byte with bit 7 = 0 selects block access. It is acknowledged only when bits 6:0 are all zero; otherwise it is not acknowledged.
- R4: In a block write, the byte after the command is a count that is acknowledged and then discarded. The data bytes that follow, each received MSB first, go to registers 0, 1, 2 in order. A data byte beyond the last register is not acknowledged and changes nothing.
- R5: A STOP after any whole data byte of a block write ends it. Registers already written keep their new values, and the registers that follow keep their old ones.
- R6: A block read, started by a repeated START with address 0xDD, returns first the count 0x03 and then registers 0, 1, 2 MSB first. Any further byte reads as 0x00. When the host does not acknowledge a byte, the slave sends nothing more and leaves SDA released.
- R7: A byte read, made of a byte command, then a repeated START, then 0xDD, returns the register at the latched offset.
- R8: A byte write stores exactly one data byte at the offset. Any further data byte in the same transaction is not acknowledged and is not stored.
- R9: After reset, register 0 = 0xFF, register 1 = 0x0F and register 2 = 0x00, and SDA is released.
- R10: Output enable clkEnable[i] equals bit i of register 0 at all times (1 = output running).
- R11: The slave changes its SDA drive only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Serial clock from the bus |
| sdaIn | input | 1 | Serial data level seen on the bus |
| sdaDriveLow | output | 1 | 1 pulls SDA low (open-drain); 0 releases it |
| clkEnable | output | 8 | Per-output clock enables taken from register 0 |

## Verification
The hardest situations to reach are the ones where the host ends a transfer on its own terms. One is a STOP in the middle of a block write. The other is a host NACK in a block read that has already run past the last register and is getting zero fill. Both need a byte-level bus model that can issue a repeated START, stop after any byte, and choose its own acknowledge bit. The bench drives SCL and SDA through such a model and wires the slave's pull-down onto SDA. It then reads the registers back over the same bus to show which bytes took effect.

// File: rtl/cfgbus_pkg.sv
package cfgbus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_COUNT,
    ST_WDATA,
    ST_RDATA,
    ST_IGNORE
  } busState_t;

  // strobes from control to datapath, each valid for one system clock
  typedef struct packed {
    logic rxShift;     // shift sampled SDA into receive byte
    logic cmdLoad;     // latch receive byte as command
    logic ptrFromRx;   // pointer from receive byte (command phase)
    logic ptrFromCmd;  // pointer from latched command (read address phase)
    logic regWrite;    // write receive byte at pointer, then advance pointer
    logic txLoadCount; // load register count into transmit byte
    logic txLoadData;  // load register at pointer, then advance pointer
    logic txShift;     // move next transmit bit to the top
  } dpStrobe_t;

endpackage

// File: rtl/cfgbus_regs.sv
module cfgbus_regs
  import cfgbus_pkg::*;
#(
  parameter int NUM_REGS = 3,
  parameter int NUM_OUTS = 8,
  parameter logic [NUM_REGS*8-1:0] REG_DEFAULTS = 24'h00_0F_FF
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strobe,
  input  logic                sdaBit,
  output logic [7:0]          rxByte,
  output logic                cmdIsByte,
  output logic                ptrInRange,
  output logic                txMsb,
  output logic [NUM_OUTS-1:0] clkEnable
);

  localparam int PTR_W = 8;
  localparam logic [PTR_W-1:0] REG_LIMIT = PTR_W'(NUM_REGS);

  logic [7:0]       cmdReg;
  logic [PTR_W-1:0] ptr;
  logic [7:0]       txReg;
  logic [7:0]       rdData;
  logic [7:0]       regFile [NUM_REGS];

  assign ptrInRange = (ptr < REG_LIMIT);
  assign cmdIsByte  = cmdReg[7];
  assign txMsb      = txReg[7];
  assign clkEnable  = regFile[0][NUM_OUTS-1:0];

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (ptr == PTR_W'(i)) rdData = regFile[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte <= '0;
      cmdReg <= '0;
      ptr    <= '0;
      txReg  <= '1;
    end else begin
      if (strobe.rxShift) rxByte <= {rxByte[6:0], sdaBit};
      if (strobe.cmdLoad) cmdReg <= rxByte;
      if (strobe.ptrFromRx)
        ptr <= rxByte[7] ? {1'b0, rxByte[6:0]} : '0;
      else if (strobe.ptrFromCmd)
        ptr <= cmdReg[7] ? {1'b0, cmdReg[6:0]} : '0;
      else if ((strobe.regWrite || strobe.txLoadData) && ptr != '1)
        ptr <= ptr + 1'b1;
      if (strobe.txLoadCount)     txReg <= 8'(NUM_REGS);
      else if (strobe.txLoadData) txReg <= rdData;
      else if (strobe.txShift)    txReg <= {txReg[6:0], 1'b1};
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : gen_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        regFile[g] <= REG_DEFAULTS[g*8 +: 8];
      else if (strobe.regWrite && ptr == PTR_W'(g))
        regFile[g] <= rxByte;
    end
  end

endmodule

// File: rtl/cfgbus_ctrl.sv
module cfgbus_ctrl
  import cfgbus_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h6E,
  parameter int         NUM_REGS = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [7:0] rxByte,
  input  logic       cmdIsByte,
  input  logic       ptrInRange,
  input  logic       txMsb,
  output dpStrobe_t  strobe,
  output logic       sdaDriveLow,
  output logic       sdaBit,
  output busState_t  busState,
  output logic [3:0] frameSlot,
  output logic       sclLevel
);

  localparam logic [3:0] SLOT_LAST = 4'd7;
  localparam logic [3:0] SLOT_ACK  = 4'd8;
  localparam logic [3:0] SLOT_PRE  = 4'd15;
  localparam logic [7:0] REG_LIMIT = 8'(NUM_REGS);

  logic sclMeta, sclS, sclPrev;
  logic sdaMeta, sdaS, sdaPrev;
  busState_t state, nextState, nextDec;
  logic [3:0] slot;
  logic ackLow, txActive, countPending, masterNack;
  logic ackDec;

  logic sclRise, sclFall, startCond, stopCond, receiving, loadNow;

  assign sclRise   = sclS & ~sclPrev;
  assign sclFall   = ~sclS & sclPrev;
  assign startCond = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopCond  = sclS & sclPrev & ~sdaPrev & sdaS;
  assign receiving = (state == ST_ADDR) || (state == ST_CMD) ||
                     (state == ST_COUNT) || (state == ST_WDATA);

  assign sdaDriveLow = ackLow | (txActive & ~txMsb);
  assign sdaBit      = sdaS;
  assign busState    = state;
  assign frameSlot   = slot;
  assign sclLevel    = sclS;

  // decision taken when the eighth bit of a received byte is in
  always_comb begin
    ackDec  = 1'b0;
    nextDec = state;
    case (state)
      ST_ADDR: begin
        ackDec  = (rxByte[7:1] == DEV_ADDR);
        nextDec = !ackDec ? ST_IGNORE : (rxByte[0] ? ST_RDATA : ST_CMD);
      end
      ST_CMD: begin
        ackDec  = rxByte[7] ? ({1'b0, rxByte[6:0]} < REG_LIMIT)
                            : (rxByte[6:0] == 7'd0);
        nextDec = !ackDec ? ST_IGNORE : (rxByte[7] ? ST_WDATA : ST_COUNT);
      end
      ST_COUNT: begin
        ackDec  = 1'b1;
        nextDec = ST_WDATA;
      end
      ST_WDATA: begin
        ackDec  = ptrInRange;
        nextDec = (ptrInRange && !cmdIsByte) ? ST_WDATA : ST_IGNORE;
      end
      default: begin
        ackDec  = 1'b0;
        nextDec = state;
      end
    endcase
  end

  assign loadNow = sclFall && (slot == SLOT_ACK) &&
                   ((state == ST_ADDR && nextState == ST_RDATA) ||
                    (state == ST_RDATA && !masterNack));

  always_comb begin
    strobe = '0;
    strobe.rxShift = sclRise && receiving && (slot < SLOT_ACK);
    if (sclFall && slot == SLOT_LAST && receiving && ackDec) begin
      case (state)
        ST_ADDR:  strobe.ptrFromCmd = rxByte[0];
        ST_CMD: begin
          strobe.cmdLoad   = 1'b1;
          strobe.ptrFromRx = 1'b1;
        end
        ST_WDATA: strobe.regWrite = 1'b1;
        default:  ;
      endcase
    end
    strobe.txShift     = sclFall && (state == ST_RDATA) && txActive &&
                         (slot < SLOT_LAST);
    strobe.txLoadCount = loadNow && countPending;
    strobe.txLoadData  = loadNow && !countPending;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclMeta <= 1'b1; sclS <= 1'b1; sclPrev <= 1'b1;
      sdaMeta <= 1'b1; sdaS <= 1'b1; sdaPrev <= 1'b1;
      state        <= ST_IDLE;
      nextState    <= ST_IDLE;
      slot         <= SLOT_PRE;
      ackLow       <= 1'b0;
      txActive     <= 1'b0;
      countPending <= 1'b0;
      masterNack   <= 1'b0;
    end else begin
      sclMeta <= sclIn; sclS <= sclMeta; sclPrev <= sclS;
      sdaMeta <= sdaIn; sdaS <= sdaMeta; sdaPrev <= sdaS;
      if (startCond) begin
        state    <= ST_ADDR;
        slot     <= SLOT_PRE;
        ackLow   <= 1'b0;
        txActive <= 1'b0;
      end else if (stopCond) begin
        state    <= ST_IDLE;
        ackLow   <= 1'b0;
        txActive <= 1'b0;
      end else begin
        if (sclRise && state == ST_RDATA && slot == SLOT_ACK)
          masterNack <= sdaS;
        if (sclFall) begin
          slot <= (slot == SLOT_ACK || slot == SLOT_PRE) ? 4'd0 : slot + 4'd1;
          if (slot == SLOT_LAST) begin
            ackLow    <= receiving && ackDec;
            txActive  <= 1'b0;
            nextState <= nextDec;
            if (state == ST_ADDR && ackDec && rxByte[0])
              countPending <= !cmdIsByte;
          end else if (slot == SLOT_ACK) begin
            ackLow <= 1'b0;
            if (state == ST_RDATA)
              state <= masterNack ? ST_IGNORE : ST_RDATA;
            else if (state != ST_IDLE && state != ST_IGNORE)
              state <= nextState;
            if (loadNow) begin
              txActive     <= 1'b1;
              countPending <= 1'b0;
            end
          end
        end
      end
    end
  end

endmodule

// File: rtl/cfgbus_slave.sv
module cfgbus_slave
  import cfgbus_pkg::*;
#(
  parameter logic [6:0]            DEV_ADDR     = 7'h6E,
  parameter int                    NUM_REGS     = 3,
  parameter int                    NUM_OUTS     = 8,
  parameter logic [NUM_REGS*8-1:0] REG_DEFAULTS = 24'h00_0F_FF
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sclIn,
  input  logic                sdaIn,
  output logic                sdaDriveLow,
  output logic [NUM_OUTS-1:0] clkEnable
);

  dpStrobe_t  strobe;
  logic [7:0] rxByte;
  logic       cmdIsByte, ptrInRange, txMsb, sdaBit, sclLevel;
  busState_t  busState;
  logic [3:0] frameSlot;

  cfgbus_ctrl #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .rxByte(rxByte), .cmdIsByte(cmdIsByte), .ptrInRange(ptrInRange),
    .txMsb(txMsb), .strobe(strobe), .sdaDriveLow(sdaDriveLow),
    .sdaBit(sdaBit), .busState(busState), .frameSlot(frameSlot),
    .sclLevel(sclLevel)
  );

  cfgbus_regs #(.NUM_REGS(NUM_REGS), .NUM_OUTS(NUM_OUTS),
                .REG_DEFAULTS(REG_DEFAULTS)) u_regs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sdaBit(sdaBit),
    .rxByte(rxByte), .cmdIsByte(cmdIsByte), .ptrInRange(ptrInRange),
    .txMsb(txMsb), .clkEnable(clkEnable)
  );

endmodule

// File: rtl/cfgbus_slave_chk.sv
module cfgbus_slave_chk
  import cfgbus_pkg::*;
#(
  parameter int NUM_OUTS = 8,
  parameter logic [NUM_OUTS-1:0] ENABLE_DEFAULT = '1
) (
  input logic                clk,
  input logic                rstN,
  input logic                sclLevel,
  input logic                sdaDriveLow,
  input logic [NUM_OUTS-1:0] clkEnable,
  input busState_t           busState,
  input logic [3:0]          frameSlot,
  input logic                regWrite,
  input logic                ptrInRange
);

  // R9: enables leave reset at their defaults
  a_r9_reset_enables: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (clkEnable == ENABLE_DEFAULT && !sdaDriveLow));

  // R11: the pull-down is only applied in the SCL low phase
  a_r11_drive_low_phase: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaDriveLow) |-> !sclLevel);

  // R1: an idle or ignoring slave never holds SDA
  a_r1_released_when_ignoring: assert property (@(posedge clk) disable iff (!rstN)
    (busState == ST_IDLE || busState == ST_IGNORE) |-> !sdaDriveLow);

  // R4: a register write only happens for an implemented register
  a_r4_write_in_range: assert property (@(posedge clk) disable iff (!rstN)
    regWrite |-> ptrInRange);

  // R6: the host's acknowledge slot of a read byte is left free
  a_r6_host_ack_slot_free: assert property (@(posedge clk) disable iff (!rstN)
    (busState == ST_RDATA && frameSlot == 4'd8) |-> !sdaDriveLow);

endmodule

bind cfgbus_slave cfgbus_slave_chk #(
  .NUM_OUTS(NUM_OUTS),
  .ENABLE_DEFAULT(REG_DEFAULTS[NUM_OUTS-1:0])
) u_chk (
  .clk(clk), .rstN(rstN), .sclLevel(sclLevel), .sdaDriveLow(sdaDriveLow),
  .clkEnable(clkEnable), .busState(busState), .frameSlot(frameSlot),
  .regWrite(strobe.regWrite), .ptrInRange(ptrInRange)
);

// File: tb/cfgbus_slave_test.sv
module cfgbus_slave_test;

  localparam int Q = 6;
  localparam int H = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1;
  logic mSda = 1'b1;
  logic sdaDriveLow;
  logic [7:0] clkEnable;
  wire  sdaBus = mSda & ~sdaDriveLow;

  int checks = 0;
  int errors = 0;
  int phaseViol = 0;
  logic prevDrive = 1'b0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  cfgbus_slave uut (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaBus),
    .sdaDriveLow(sdaDriveLow), .clkEnable(clkEnable)
  );

  // R11 monitor: the slave's drive must not move while SCL is high
  always @(negedge clk) begin
    if (rstN && sdaDriveLow !== prevDrive && mScl) phaseViol++;
    prevDrive = sdaDriveLow;
  end

  // {expected command ack, offset, data}
  localparam logic [16:0] VEC [6] = '{
    {1'b1, 8'h00, 8'hA5},
    {1'b1, 8'h01, 8'h3C},
    {1'b1, 8'h02, 8'h81},
    {1'b0, 8'h03, 8'h11},
    {1'b0, 8'h7F, 8'h22},
    {1'b1, 8'h00, 8'h96}
  };

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic checkVal(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, actual, expected);
    end
  endtask

  task automatic busStart();
    mSda = 1'b1; waitClk(Q);
    mScl = 1'b1; waitClk(Q);
    mSda = 1'b0; waitClk(Q);
    mScl = 1'b0; waitClk(Q);
  endtask

  task automatic busStop();
    mSda = 1'b0; waitClk(Q);
    mScl = 1'b1; waitClk(Q);
    mSda = 1'b1; waitClk(Q);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      mSda = b[i]; waitClk(Q);
      mScl = 1'b1; waitClk(H);
      mScl = 1'b0; waitClk(Q);
    end
    mSda = 1'b1; waitClk(Q);
    mScl = 1'b1; waitClk(H / 2);
    ack = !sdaBus; waitClk(H / 2);
    mScl = 1'b0; waitClk(Q);
  endtask

  task automatic recvByte(input logic hostAck, output logic [7:0] b);
    mSda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitClk(Q);
      mScl = 1'b1; waitClk(H / 2);
      b[i] = sdaBus; waitClk(H / 2);
      mScl = 1'b0; waitClk(Q);
    end
    mSda = !hostAck; waitClk(Q);
    mScl = 1'b1; waitClk(H);
    mScl = 1'b0; waitClk(Q);
    mSda = 1'b1;
  endtask

  task automatic byteWrite(input logic [6:0] off, input logic [7:0] data,
                           output logic cmdAck, output logic dataAck);
    logic a;
    busStart();
    sendByte(8'hDC, a);
    sendByte({1'b1, off}, cmdAck);
    dataAck = 1'b0;
    if (cmdAck) sendByte(data, dataAck);
    busStop();
  endtask

  task automatic byteRead(input logic [6:0] off, output logic cmdAck,
                          output logic [7:0] data);
    logic a;
    busStart();
    sendByte(8'hDC, a);
    sendByte({1'b1, off}, cmdAck);
    data = 8'h00;
    if (cmdAck) begin
      busStart();
      sendByte(8'hDD, a);
      recvByte(1'b0, data);
    end
    busStop();
  endtask

  initial begin
    logic ack, ack2;
    logic [7:0] rd;
    waitClk(5);
    // R9: reset state
    checkVal("R9 enables", clkEnable, 8'hFF);
    checkVal("R9 sda released", sdaDriveLow, 0);
    rstN = 1'b1;
    waitClk(5);
    checkVal("R9 enables after reset", clkEnable, 8'hFF);
    byteRead(7'd1, ack, rd);
    checkVal("R9 reg1 default", rd, 8'h0F);
    byteRead(7'd2, ack, rd);
    checkVal("R9 reg2 default", rd, 8'h00);

    // R2 R7 R10: vector table of byte writes and read-backs
    for (int v = 0; v < 6; v++) begin
      logic expAck;
      logic [7:0] off, data;
      {expAck, off, data} = VEC[v];
      byteWrite(off[6:0], data, ack, ack2);
      checkVal("R2 command ack", ack, expAck);
      if (expAck) begin
        checkVal("R8 data ack", ack2, 1);
        byteRead(off[6:0], ack, rd);
        checkVal("R7 byte read data", rd, data);
        if (off == 8'h00) checkVal("R10 enables follow reg0", clkEnable, data);
      end else begin
        byteRead(off[6:0], ack, rd);
        checkVal("R2 read cmd nack", ack, 0);
      end
    end

    // R1: foreign address
    busStart();
    sendByte(8'hA0, ack);
    checkVal("R1 foreign address nack", ack, 0);
    sendByte(8'h80, ack);
    checkVal("R1 following byte nack", ack, 0);
    busStop();

    // R4: full block write plus one extra byte
    busStart();
    sendByte(8'hDC, ack);
    checkVal("R1 own address ack", ack, 1);
    sendByte(8'h00, ack);
    checkVal("R3 block command ack", ack, 1);
    sendByte(8'h03, ack);
    checkVal("R4 count ack", ack, 1);
    sendByte(8'h11, ack);
    sendByte(8'h22, ack2);
    checkVal("R4 data ack", ack & ack2, 1);
    sendByte(8'h33, ack);
    checkVal("R4 last data ack", ack, 1);
    sendByte(8'h44, ack);
    checkVal("R4 overflow nack", ack, 0);
    busStop();
    checkVal("R10 enables after block write", clkEnable, 8'h11);

    // R6: block read with zero fill past the end
    busStart();
    sendByte(8'hDC, ack);
    sendByte(8'h00, ack);
    busStart();
    sendByte(8'hDD, ack);
    checkVal("R6 read address ack", ack, 1);
    recvByte(1'b1, rd); checkVal("R6 count byte", rd, 8'h03);
    recvByte(1'b1, rd); checkVal("R6 reg0", rd, 8'h11);
    recvByte(1'b1, rd); checkVal("R6 reg1", rd, 8'h22);
    recvByte(1'b1, rd); checkVal("R6 reg2", rd, 8'h33);
    recvByte(1'b0, rd); checkVal("R6 zero fill", rd, 8'h00);
    waitClk(4 * H);
    checkVal("R6 released after host nack", sdaDriveLow, 0);
    recvByte(1'b0, rd); checkVal("R6 nothing sent after nack", rd, 8'hFF);
    busStop();

    // R5: block write stopped after the first data byte
    busStart();
    sendByte(8'hDC, ack);
    sendByte(8'h00, ack);
    sendByte(8'h03, ack);
    sendByte(8'h5A, ack);
    busStop();
    byteRead(7'd0, ack, rd);
    checkVal("R5 written byte kept", rd, 8'h5A);
    byteRead(7'd1, ack, rd);
    checkVal("R5 later register unchanged", rd, 8'h22);

    // R3: block command with nonzero low bits
    busStart();
    sendByte(8'hDC, ack);
    sendByte(8'h05, ack);
    checkVal("R3 bad block command nack", ack, 0);
    busStop();

    // R8: byte write followed by an extra byte
    busStart();
    sendByte(8'hDC, ack);
    sendByte(8'h81, ack);
    sendByte(8'h77, ack);
    checkVal("R8 single data ack", ack, 1);
    sendByte(8'h66, ack);
    checkVal("R8 extra byte nack", ack, 0);
    busStop();
    byteRead(7'd1, ack, rd);
    checkVal("R8 target written", rd, 8'h77);
    byteRead(7'd2, ack, rd);
    checkVal("R8 neighbour untouched", rd, 8'h33);

    checkVal("R11 drive changes in scl high", phaseViol, 0);

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule